// File: doc/BRIEF.md
# Three-Wire Serial Register Bus Master

This block is the host side of a three-wire control bus. The bus has an active-low frame enable, a serial clock and one data line that both ends share. A local parallel request names the operation (read or write), a 7-bit register address and, for writes, a 16-bit word. The block turns that request into a framed serial telegram.

A telegram opens with one spare rising clock edge while enable is still high. The far end has no clock of its own, so it needs this edge to wake. The block then drops enable and shifts out a start bit, the operation bit and the address. A write continues with the data word. After the word, enable goes high and one last rising edge commits the word. A read lets go of the data line after the address. It waits out the turnaround and samples the 16 returned bits on falling clock edges.

The serial clock comes from the system clock through a parameterised divider. When a transfer ends, a one-cycle done pulse is raised. For a read, the captured word sits on `rdata` during that pulse.

Top module: `sreg3w_master`

## Requirements
- R1: While `busy` is low, `ser_en_n` is high, `ser_doe` is low and `ser_clk` is low. This is also the state after reset.
- R2: Each `ser_clk` level lasts `HALF_DIV` system clocks. The first rising edge comes `HALF_DIV` cycles after the request is accepted, and `ser_en_n` is still high at that edge.
- R3: `ser_en_n` falls on the first falling edge of `ser_clk` and stays low until the end of the frame.
- R4: The master drives `ser_dout` with `ser_doe` high, changing the bit only on falling edges. The bit order is: start bit 1 (sampled at rising edge 2), operation bit (0 = write, 1 = read; rising edge 3), then address bits MSB first (rising edges 4 to 10).
- R5: On a write, the 16 data bits follow MSB first (rising edges 11 to 26). The master drives the line from the start bit to the last data bit.
- R6: On a write, `ser_en_n` rises and the line is released on falling edge 26. Rising edge 27 then occurs with enable high, and the transfer ends on falling edge 27. The slave has committed the word by then.
- R7: On a read, the master releases the line on falling edge 10, just after the last address bit. It does not drive the line again in that frame. The slave may drive from rising edge 13.
- R8: On a read, the master samples `ser_din` on falling edges 13 to 28 and assembles the bits MSB first. `ser_en_n` rises on falling edge 28, and `rdata` holds the word while `done` is high.
- R9: `busy` rises on the clock edge that accepts a request. It falls on the same edge that raises `done`, and `done` is high for exactly one cycle.
- R10: A request presented while `busy` is high is ignored. It starts no frame and changes no register at the slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, taken when not busy |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | AW | Register address |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read word, valid with done on reads |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_en_n | output | 1 | Active-low frame enable |
| ser_dout | output | 1 | Serial data driven by the master |
| ser_doe | output | 1 | Output enable for the shared data line |
| ser_din | input | 1 | Serial data as seen on the shared line |

## Verification
The assertions assume that `req` and its fields are synchronous to `clk`. They also assume that `ser_din` is stable whenever the master samples it. The bench meets both conditions. It changes the request inputs shortly after a rising system clock edge. Its slave model updates its driven bit only on rising serial clock edges, so the bit is settled by the falling edge on which the master samples it. The shared line resolves the master's drive first, then the slave's, then a pull-up. The bench flags any cycle in which both ends drive the line together.

// File: rtl/sreg3w_master.sv
module sreg3w_master #(
  parameter int HALF_DIV = 3,
  parameter int AW       = 7,
  parameter int DW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_read,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          ser_clk,
  output logic          ser_en_n,
  output logic          ser_dout,
  output logic          ser_doe,
  input  logic          ser_din
);

  localparam int TW  = 2 + AW + DW;
  localparam int CW  = $clog2(AW + DW + 6) + 1;
  localparam int DVW = $clog2(HALF_DIV + 1);

  localparam logic [CW-1:0] F_DRV_RD = CW'(AW + 2);
  localparam logic [CW-1:0] F_DRV_WR = CW'(AW + DW + 2);
  localparam logic [CW-1:0] F_REL_RD = CW'(AW + 3);
  localparam logic [CW-1:0] F_ENH_WR = CW'(AW + DW + 3);
  localparam logic [CW-1:0] F_END_WR = CW'(AW + DW + 4);
  localparam logic [CW-1:0] F_CAP0   = CW'(AW + 6);
  localparam logic [CW-1:0] F_END_RD = CW'(AW + DW + 5);

  logic [DVW-1:0] div_q;
  logic [CW-1:0]  rise_q;
  logic [TW-1:0]  tx_q;
  logic [DW-1:0]  rx_q;
  logic           rd_q;

  wire            tick     = busy && (div_q == DVW'(HALF_DIV - 1));
  wire [CW-1:0]   drv_last = rd_q ? F_DRV_RD : F_DRV_WR;

  assign rdata = rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      ser_clk  <= 1'b0;
      ser_en_n <= 1'b1;
      ser_dout <= 1'b0;
      ser_doe  <= 1'b0;
      div_q    <= '0;
      rise_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      rd_q     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy   <= 1'b1;
          rd_q   <= req_read;
          tx_q   <= {1'b1, req_read, req_addr, req_wdata};
          div_q  <= '0;
          rise_q <= '0;
        end
      end else begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (!ser_clk) begin
            ser_clk <= 1'b1;
            rise_q  <= rise_q + 1'b1;
          end else begin
            ser_clk <= 1'b0;
            if (rise_q == CW'(1)) ser_en_n <= 1'b0;
            if (rise_q <= drv_last) begin
              ser_doe  <= 1'b1;
              ser_dout <= tx_q[TW-1];
              tx_q     <= tx_q << 1;
            end
            if (rd_q) begin
              if (rise_q == F_REL_RD) ser_doe <= 1'b0;
              if (rise_q >= F_CAP0) rx_q <= {rx_q[DW-2:0], ser_din};
              if (rise_q == F_END_RD) begin
                ser_en_n <= 1'b1;
                busy     <= 1'b0;
                done     <= 1'b1;
              end
            end else begin
              if (rise_q == F_ENH_WR) begin
                ser_en_n <= 1'b1;
                ser_doe  <= 1'b0;
              end
              if (rise_q == F_END_WR) begin
                busy <= 1'b0;
                done <= 1'b1;
              end
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/sreg3w_master_chk.sv
module sreg3w_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic busy,
  input logic done,
  input logic ser_clk,
  input logic ser_en_n,
  input logic ser_dout,
  input logic ser_doe
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_en_n && !ser_doe && !ser_clk)); // R1

  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(req) && ser_en_n)); // R2

  AST_EN_LOW_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_en_n) |-> $fell(ser_clk)); // R3

  AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> ($stable(ser_dout) && $stable(ser_doe))); // R4

  AST_EN_HIGH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_en_n) |-> $fell(ser_clk)); // R6

  AST_DRIVE_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ser_doe |-> !ser_en_n); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy)); // R9

endmodule

bind sreg3w_master sreg3w_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .busy     (busy),
  .done     (done),
  .ser_clk  (ser_clk),
  .ser_en_n (ser_en_n),
  .ser_dout (ser_dout),
  .ser_doe  (ser_doe)
);

// File: tb/test_sreg3w_master.sv
`timescale 1ns/1ps
module test_sreg3w_master;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_read = 1'b0;
  logic [6:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, ser_clk, ser_en_n, ser_dout, ser_doe, ser_din;
  logic [15:0] rdata;

  always #5 clk = ~clk;

  sreg3w_master #(.HALF_DIV(HALF), .AW(7), .DW(16)) i_sreg3w_master (
    .clk(clk), .rst_n(rst_n), .req(req), .req_read(req_read),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .ser_clk(ser_clk), .ser_en_n(ser_en_n),
    .ser_dout(ser_dout), .ser_doe(ser_doe), .ser_din(ser_din));

  int vectors = 0, fails = 0, cyc = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // slave model with pull-up on the shared line
  logic s_oe = 1'b0, s_o = 1'b0, s_rd = 1'b0;
  logic [6:0] s_addr = '0;
  logic [15:0] s_wd = '0;
  int s_c = 0;
  logic [15:0] s_mem [128];
  logic [15:0] ref_mem [128];

  assign ser_din = ser_doe ? ser_dout : (s_oe ? s_o : 1'b1);

  always @(posedge ser_clk or posedge ser_en_n) begin
    if (ser_en_n) begin
      s_oe <= 1'b0;
      if (ser_clk && s_c == 25 && !s_rd) s_mem[s_addr] <= s_wd;
      if (ser_clk || s_rd) s_c <= 0;
    end else begin
      s_c <= s_c + 1;
      if (s_c + 1 == 2) s_rd <= ser_din;
      if (s_c + 1 >= 3 && s_c + 1 <= 9) s_addr <= {s_addr[5:0], ser_din};
      if (s_c + 1 >= 10 && s_c + 1 <= 25 && !s_rd) s_wd <= {s_wd[14:0], ser_din};
      if (s_rd && s_c + 1 >= 12 && s_c + 1 <= 27) begin
        s_oe <= 1'b1;
        s_o  <= s_mem[s_addr][27 - (s_c + 1)];
      end
    end
  end

  // cycle-by-cycle reference model
  bit m_act = 0, m_rd = 0;
  int m_t = 0;
  logic [24:0] m_seq = '0;
  logic [15:0] m_exp = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      int j, jend;
      bit e_busy, e_done, e_sclk, e_en, e_oe;
      j = m_t / HALF;
      jend = m_rd ? 56 : 54;
      e_busy = m_act && m_t < jend * HALF;
      e_done = m_act && m_t == jend * HALF;
      e_sclk = e_busy && (j % 2 == 1);
      e_en   = !(e_busy && j >= 2 && j < (m_rd ? 56 : 52));
      e_oe   = e_busy && j >= 2 && j <= (m_rd ? 19 : 51);
      check(busy == e_busy, "R9 busy", busy, e_busy);
      check(done == e_done, "R9 done", done, e_done);
      check(ser_clk == e_sclk, "R2 ser_clk", ser_clk, e_sclk);
      check(ser_en_n == e_en, m_rd ? "R3/R8 ser_en_n" : "R3/R6 ser_en_n", ser_en_n, e_en);
      check(ser_doe == e_oe, m_rd ? "R7 ser_doe" : "R5 ser_doe", ser_doe, e_oe);
      if (e_oe) check(ser_dout == m_seq[25 - j/2], "R4/R5 ser_dout", ser_dout, m_seq[25 - j/2]);
      if (ser_doe && s_oe) check(0, "R7 line contention", 1, 0);
      if (e_done && m_rd) check(rdata == m_exp, "R8 rdata", rdata, m_exp);
      if (m_act) begin
        if (m_t == jend * HALF) m_act = 0;
        else m_t++;
      end
      // R10: a request is only taken when the model is idle
      if (!m_act && req) begin
        m_act = 1; m_t = 0; m_rd = req_read;
        m_seq = {1'b1, req_read, req_addr, req_wdata};
        if (req_read) m_exp = ref_mem[req_addr];
        else ref_mem[req_addr] = req_wdata;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic issue(input bit rd, input logic [6:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    req = 1'b1; req_read = rd; req_addr = a; req_wdata = d;
    @(posedge clk); #2;
    req = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic xfer(input bit rd, input logic [6:0] a, input logic [15:0] d);
    issue(rd, a, d);
    wait_done();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      s_mem[i]   = 16'(i * 16'h0101) ^ 16'hA5C3;
      ref_mem[i] = 16'(i * 16'h0101) ^ 16'hA5C3;
    end
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(!busy && ser_en_n && !ser_doe && !ser_clk && !done, "R1 reset idle", busy, 0);

    xfer(0, 7'h00, 16'hFFFF);
    xfer(0, 7'h7F, 16'h0000);
    xfer(0, 7'h55, 16'hA5A5);
    xfer(1, 7'h00, 16'h1234);
    xfer(1, 7'h7F, 16'h0000);
    xfer(1, 7'h55, 16'h0000);
    xfer(1, 7'h2A, 16'h0000);

    // R10: request during a write must be ignored
    issue(0, 7'h11, 16'hBEEF);
    repeat (20) @(posedge clk);
    #2 req = 1'b1; req_read = 1'b0; req_addr = 7'h12; req_wdata = 16'hDEAD;
    @(posedge clk); #2 req = 1'b0;
    wait_done();
    repeat (5) @(negedge clk);
    check(!busy, "R10 no frame after ignored request", busy, 0);
    check(s_mem[7'h12] == ref_mem[7'h12], "R10 slave reg untouched", s_mem[7'h12], ref_mem[7'h12]);

    // back-to-back: request held high through done
    @(posedge clk); #2;
    req = 1'b1; req_read = 1'b1; req_addr = 7'h11; req_wdata = '0;
    while (!done) @(negedge clk);
    @(posedge clk); #2 req = 1'b0;
    wait_done();
    xfer(1, 7'h12, 16'h0000);

    repeat (4) @(negedge clk);
    for (int i = 0; i < 128; i++)
      check(s_mem[i] == ref_mem[i], "R6 slave commit", s_mem[i], ref_mem[i]);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule